// File: doc/BRIEF.md
# Condition Register with Per-Field Dispatch Interlocks

This block holds a 32-bit condition register built from eight 4-bit fields. It also keeps a reservation scoreboard with one lock bit per field. A dispatch stage uses the scoreboard to decide whether a candidate instruction may issue.

The register accepts five kinds of update:

- a whole-field write of a compare result into a selected field;
- a record-bit write into a fixed field that depends on the producing unit;
- a masked move that copies any set of fields from a 32-bit source;
- a single-bit logical result computed from two register bits;
- an interrupt restore that loads a saved 32-bit snapshot.

The dispatch check takes up to two source field indices and one target field index. Each index has its own valid flag. The check raises a hold in the same cycle if any valid index names a locked field. A reserve port sets a field's lock when a CR-setting instruction issues. A release port clears it when that instruction completes. The register value and the lock vector are registered outputs. Reset is synchronous and active high.

Top module: `cr_interlock`

## Requirements
- R1: While `rst` is high at a clock edge, the register and all eight locks become zero.
- R2: A compare write loads `cmp_val` into field `cmp_fld`. Field f occupies bits [4f+3:4f] of `cr_q`.
- R3: A record write loads `rec_val` into field 0 when `rec_unit` is 0 (fixed-point) and into field 1 when `rec_unit` is 1 (floating-point).
- R4: A masked move copies field f of `mtc_data` into field f for every set bit f of `mtc_mask`. Fields whose mask bit is clear keep their value.
- R5: A logic write changes only bit `lcr_dst`. The new value is op(`cr_q[lcr_a]`, `cr_q[lcr_b]`), using the operand values from before the edge. The `lcr_op` encoding is 0 AND, 1 OR, 2 XOR, 3 XNOR.
- R6: When several writes hit the same bits in one cycle, the order of precedence from lowest to highest is masked move, compare, record, logic bit.
- R7: An interrupt restore loads `irq_snap` into the register and overrides every other write in that cycle.
- R8: A reserve sets the lock of `rsv_fld` at the next edge. A release clears the lock of `rel_fld` at the next edge. Other locks are unchanged.
- R9: When a reserve and a release name the same field in the same cycle, the lock ends up set.
- R10: An interrupt restore clears all eight locks at the same edge, including any lock being reserved in that cycle.
- R11: `chk_hold` is a combinational output. It is 1 in the same cycle if and only if some index whose valid flag is set names a locked field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_we | input | 1 | Compare write enable |
| cmp_fld | input | 3 | Compare target field |
| cmp_val | input | 4 | Compare result |
| rec_we | input | 1 | Record write enable |
| rec_unit | input | 1 | 0 = fixed-point (field 0), 1 = floating-point (field 1) |
| rec_val | input | 4 | Record result |
| mtc_we | input | 1 | Masked move enable |
| mtc_mask | input | 8 | Field select of masked move |
| mtc_data | input | 32 | Masked move source |
| lcr_we | input | 1 | Logic bit write enable |
| lcr_op | input | 2 | Logic operation |
| lcr_a | input | 5 | First operand bit index |
| lcr_b | input | 5 | Second operand bit index |
| lcr_dst | input | 5 | Destination bit index |
| irq_restore | input | 1 | Interrupt restore strobe |
| irq_snap | input | 32 | Saved register value |
| rsv_we | input | 1 | Reserve strobe |
| rsv_fld | input | 3 | Field to reserve |
| rel_we | input | 1 | Release strobe |
| rel_fld | input | 3 | Field to release |
| chk_s0_v | input | 1 | First source index valid |
| chk_s0 | input | 3 | First source field |
| chk_s1_v | input | 1 | Second source index valid |
| chk_s1 | input | 3 | Second source field |
| chk_t_v | input | 1 | Target index valid |
| chk_t | input | 3 | Target field |
| chk_hold | output | 1 | Dispatch must wait |
| cr_q | output | 32 | Register value |
| lock_q | output | 8 | Per-field lock bits |

## Verification
On every cycle, the assertions check three groups of behaviour:

- the restore load and the lock flush;
- reserve beating release, and a lone release clearing its lock;
- a hold whenever a valid index meets a locked field, and no hold when every lock is clear.

Two behaviours only the bench scenarios can show. The first is the precedence chain when several writes overlap the same bits. The second is that a logic write reads operands from before the edge while other writes land in the same cycle. The bench tracks these in a behavioural model that is compared on every clock.

// File: rtl/crx_pkg.sv
package crx_pkg;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_OR  = 2'd1,
    LOP_XOR = 2'd2,
    LOP_EQV = 2'd3
  } lcr_op_e;

  function automatic logic lcr_eval(lcr_op_e op, logic a, logic b);
    logic r;
    case (op)
      LOP_AND: r = a & b;
      LOP_OR:  r = a | b;
      LOP_XOR: r = a ^ b;
      default: r = ~(a ^ b);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/crx_store.sv
module crx_store #(
  parameter int NF     = 8,
  parameter int FW     = 4,
  parameter int REC_FX = 0,
  parameter int REC_FP = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmp_we,
  input  logic [$clog2(NF)-1:0]         cmp_fld,
  input  logic [FW-1:0]                 cmp_val,
  input  logic                          rec_we,
  input  logic                          rec_unit,
  input  logic [FW-1:0]                 rec_val,
  input  logic                          mtc_we,
  input  logic [NF-1:0]                 mtc_mask,
  input  logic [NF*FW-1:0]              mtc_data,
  input  logic                          lcr_we,
  input  logic [1:0]                    lcr_op,
  input  logic [$clog2(NF*FW)-1:0]      lcr_a,
  input  logic [$clog2(NF*FW)-1:0]      lcr_b,
  input  logic [$clog2(NF*FW)-1:0]      lcr_dst,
  input  logic                          rest_we,
  input  logic [NF*FW-1:0]              rest_val,
  output logic [NF*FW-1:0]              cr_q
);
  import crx_pkg::*;

  localparam int CRW = NF * FW;
  localparam int FIX = $clog2(NF);

  logic [FIX-1:0] rec_fld;
  logic [FW-1:0]  field_nx [NF];
  logic [CRW-1:0] cr_nx;
  logic           lbit;

  assign rec_fld = rec_unit ? FIX'(REC_FP) : FIX'(REC_FX);

  // per-field merge: later stage of the chain wins
  for (genvar f = 0; f < NF; f++) begin : g_fld
    logic hit_mtc, hit_cmp, hit_rec;
    assign hit_mtc = mtc_we && mtc_mask[f];
    assign hit_cmp = cmp_we && (cmp_fld == FIX'(f));
    assign hit_rec = rec_we && (rec_fld == FIX'(f));
    assign field_nx[f] = hit_rec ? rec_val :
                         hit_cmp ? cmp_val :
                         hit_mtc ? mtc_data[f*FW +: FW] :
                                   cr_q[f*FW +: FW];
  end

  assign lbit = lcr_eval(lcr_op_e'(lcr_op), cr_q[lcr_a], cr_q[lcr_b]);

  always_comb begin
    for (int f = 0; f < NF; f++) cr_nx[f*FW +: FW] = field_nx[f];
    if (lcr_we) cr_nx[lcr_dst] = lbit;
  end

  always_ff @(posedge clk) begin
    if (rst)          cr_q <= '0;
    else if (rest_we) cr_q <= rest_val;
    else              cr_q <= cr_nx;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> cr_q == '0);

  // R7
  restore_load_chk: assert property (@(posedge clk) disable iff (rst)
    rest_we |=> cr_q == $past(rest_val));

  // R2
  cmp_field_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && !rest_we && !rec_we && !lcr_we) |=>
      cr_q[$past(cmp_fld)*FW +: FW] == $past(cmp_val));

  // R3
  rec_field_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_we && !rest_we && !lcr_we) |=>
      cr_q[($past(rec_unit) ? REC_FP : REC_FX)*FW +: FW] == $past(rec_val));

endmodule

// File: rtl/crx_locks.sv
module crx_locks #(
  parameter int NF = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rsv_we,
  input  logic [$clog2(NF)-1:0] rsv_fld,
  input  logic                  rel_we,
  input  logic [$clog2(NF)-1:0] rel_fld,
  input  logic                  flush,
  output logic [NF-1:0]         lock_q
);
  localparam int FIX = $clog2(NF);

  logic [NF-1:0] set_vec, clr_vec;

  for (genvar f = 0; f < NF; f++) begin : g_dec
    assign set_vec[f] = rsv_we && (rsv_fld == FIX'(f));
    assign clr_vec[f] = rel_we && (rel_fld == FIX'(f));
  end

  always_ff @(posedge clk) begin
    if (rst || flush) lock_q <= '0;
    else              lock_q <= (lock_q & ~clr_vec) | set_vec;
  end

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> lock_q == '0);

  // R9
  rsv_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (rsv_we && !flush) |=> lock_q[$past(rsv_fld)]);

  // R8
  rel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_we && !flush && !(rsv_we && rsv_fld == rel_fld)) |=>
      !lock_q[$past(rel_fld)]);

endmodule

// File: rtl/crx_dispatch.sv
module crx_dispatch #(
  parameter int NF    = 8,
  parameter int NPORT = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NPORT-1:0]                    idx_v,
  input  logic [NPORT-1:0][$clog2(NF)-1:0]    idx,
  input  logic [NF-1:0]                       lock_q,
  output logic                                hold
);
  logic [NPORT-1:0] hit;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign hit[p] = idx_v[p] && lock_q[idx[p]];
  end

  assign hold = |hit;

  // R11
  no_lock_go_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q == '0) |-> !hold);

  // R11
  src0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_v[0] && lock_q[idx[0]]) |-> hold);

endmodule

// File: rtl/cr_interlock.sv
module cr_interlock #(
  parameter int NF     = 8,
  parameter int FW     = 4,
  parameter int REC_FX = 0,
  parameter int REC_FP = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmp_we,
  input  logic [$clog2(NF)-1:0]         cmp_fld,
  input  logic [FW-1:0]                 cmp_val,
  input  logic                          rec_we,
  input  logic                          rec_unit,
  input  logic [FW-1:0]                 rec_val,
  input  logic                          mtc_we,
  input  logic [NF-1:0]                 mtc_mask,
  input  logic [NF*FW-1:0]              mtc_data,
  input  logic                          lcr_we,
  input  logic [1:0]                    lcr_op,
  input  logic [$clog2(NF*FW)-1:0]      lcr_a,
  input  logic [$clog2(NF*FW)-1:0]      lcr_b,
  input  logic [$clog2(NF*FW)-1:0]      lcr_dst,
  input  logic                          irq_restore,
  input  logic [NF*FW-1:0]              irq_snap,
  input  logic                          rsv_we,
  input  logic [$clog2(NF)-1:0]         rsv_fld,
  input  logic                          rel_we,
  input  logic [$clog2(NF)-1:0]         rel_fld,
  input  logic                          chk_s0_v,
  input  logic [$clog2(NF)-1:0]         chk_s0,
  input  logic                          chk_s1_v,
  input  logic [$clog2(NF)-1:0]         chk_s1,
  input  logic                          chk_t_v,
  input  logic [$clog2(NF)-1:0]         chk_t,
  output logic                          chk_hold,
  output logic [NF*FW-1:0]              cr_q,
  output logic [NF-1:0]                 lock_q
);
  localparam int FIX   = $clog2(NF);
  localparam int NPORT = 3;

  logic [NPORT-1:0]           port_v;
  logic [NPORT-1:0][FIX-1:0]  port_idx;

  assign port_v   = {chk_t_v, chk_s1_v, chk_s0_v};
  assign port_idx = {chk_t, chk_s1, chk_s0};

  crx_store #(.NF(NF), .FW(FW), .REC_FX(REC_FX), .REC_FP(REC_FP)) u_store (
    .clk      (clk),
    .rst      (rst),
    .cmp_we   (cmp_we),
    .cmp_fld  (cmp_fld),
    .cmp_val  (cmp_val),
    .rec_we   (rec_we),
    .rec_unit (rec_unit),
    .rec_val  (rec_val),
    .mtc_we   (mtc_we),
    .mtc_mask (mtc_mask),
    .mtc_data (mtc_data),
    .lcr_we   (lcr_we),
    .lcr_op   (lcr_op),
    .lcr_a    (lcr_a),
    .lcr_b    (lcr_b),
    .lcr_dst  (lcr_dst),
    .rest_we  (irq_restore),
    .rest_val (irq_snap),
    .cr_q     (cr_q)
  );

  crx_locks #(.NF(NF)) u_locks (
    .clk     (clk),
    .rst     (rst),
    .rsv_we  (rsv_we),
    .rsv_fld (rsv_fld),
    .rel_we  (rel_we),
    .rel_fld (rel_fld),
    .flush   (irq_restore),
    .lock_q  (lock_q)
  );

  crx_dispatch #(.NF(NF), .NPORT(NPORT)) u_disp (
    .clk    (clk),
    .rst    (rst),
    .idx_v  (port_v),
    .idx    (port_idx),
    .lock_q (lock_q),
    .hold   (chk_hold)
  );

endmodule

// File: tb/tb_cr_interlock.sv
`timescale 1ns/1ps
module tb_cr_interlock;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cmp_we, rec_we, rec_unit, mtc_we, lcr_we, irq_restore;
  logic rsv_we, rel_we, chk_s0_v, chk_s1_v, chk_t_v, chk_hold;
  logic [2:0] cmp_fld, rsv_fld, rel_fld, chk_s0, chk_s1, chk_t;
  logic [3:0] cmp_val, rec_val;
  logic [7:0] mtc_mask, lock_q;
  logic [31:0] mtc_data, irq_snap, cr_q;
  logic [1:0] lcr_op;
  logic [4:0] lcr_a, lcr_b, lcr_dst;

  cr_interlock dut (.*);

  logic [31:0] m_cr;
  logic [7:0]  m_lock;
  int checks = 0, fails = 0;
  string req = "R1";
  bit done = 0;

  task automatic idle();
    rst = 0; cmp_we = 0; rec_we = 0; mtc_we = 0; lcr_we = 0; irq_restore = 0;
    rsv_we = 0; rel_we = 0; chk_s0_v = 0; chk_s1_v = 0; chk_t_v = 0;
    cmp_fld = 0; rsv_fld = 0; rel_fld = 0; chk_s0 = 0; chk_s1 = 0; chk_t = 0;
    cmp_val = 0; rec_val = 0; rec_unit = 0; mtc_mask = 0; mtc_data = 0;
    irq_snap = 0; lcr_op = 0; lcr_a = 0; lcr_b = 0; lcr_dst = 0;
  endtask

  function automatic logic lop(logic [1:0] op, logic a, logic b);
    case (op)
      2'd0: return a & b;
      2'd1: return a | b;
      2'd2: return a ^ b;
      default: return a ~^ b;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // compare current outputs, then advance the model and the clock
  task automatic cycle();
    logic [31:0] ncr;
    logic [7:0]  nl;
    logic        eh;
    #1;
    eh = (chk_s0_v && m_lock[chk_s0]) || (chk_s1_v && m_lock[chk_s1]) ||
         (chk_t_v && m_lock[chk_t]);
    chk("cr_q", cr_q, m_cr);
    chk("lock_q", {24'd0, lock_q}, {24'd0, m_lock});
    chk("chk_hold", {31'd0, chk_hold}, {31'd0, eh});
    ncr = m_cr; nl = m_lock;
    if (rst) begin ncr = 0; nl = 0; end
    else if (irq_restore) begin ncr = irq_snap; nl = 0; end
    else begin
      for (int f = 0; f < 8; f++) if (mtc_we && mtc_mask[f]) ncr[f*4 +: 4] = mtc_data[f*4 +: 4];
      if (cmp_we) ncr[cmp_fld*4 +: 4] = cmp_val;
      if (rec_we) ncr[(rec_unit ? 1 : 0)*4 +: 4] = rec_val;
      if (lcr_we) ncr[lcr_dst] = lop(lcr_op, m_cr[lcr_a], m_cr[lcr_b]);
      if (rel_we) nl[rel_fld] = 1'b0;
      if (rsv_we) nl[rsv_fld] = 1'b1;
    end
    @(posedge clk);
    m_cr = ncr; m_lock = nl;
    @(negedge clk);
  endtask

  initial begin
    idle();
    m_cr = 'x; m_lock = 'x;
    @(negedge clk);
    rst = 1;
    @(posedge clk); m_cr = 0; m_lock = 0; @(negedge clk);
    req = "R1"; cycle();
    rst = 0;

    req = "R2";
    for (int f = 0; f < 8; f++) begin
      idle(); cmp_we = 1; cmp_fld = 3'(f); cmp_val = 4'(f + 9); cycle();
    end
    idle(); cycle();

    req = "R3";
    idle(); rec_we = 1; rec_unit = 0; rec_val = 4'hC; cycle();
    idle(); rec_we = 1; rec_unit = 1; rec_val = 4'h3; cycle();
    idle(); cycle();

    req = "R4";
    idle(); mtc_we = 1; mtc_mask = 8'hA5; mtc_data = 32'h1234_5678; cycle();
    idle(); mtc_we = 1; mtc_mask = 8'h00; mtc_data = 32'hFFFF_FFFF; cycle();
    idle(); mtc_we = 1; mtc_mask = 8'hFF; mtc_data = 32'h9ABC_DEF0; cycle();
    idle(); cycle();

    req = "R5";
    for (int op = 0; op < 4; op++) begin
      idle(); lcr_we = 1; lcr_op = 2'(op); lcr_a = 5'(op * 7); lcr_b = 5'(31 - op);
      lcr_dst = 5'(op * 5 + 2); cycle();
    end
    idle(); lcr_we = 1; lcr_op = 2'd3; lcr_a = 5'd4; lcr_b = 5'd4; lcr_dst = 5'd4; cycle();
    idle(); cycle();

    req = "R6";
    idle(); mtc_we = 1; mtc_mask = 8'hFF; mtc_data = 32'h0; cmp_we = 1; cmp_fld = 0;
    cmp_val = 4'hA; rec_we = 1; rec_unit = 0; rec_val = 4'h5; lcr_we = 1; lcr_op = 2'd3;
    lcr_a = 5'd31; lcr_b = 5'd30; lcr_dst = 5'd1; cycle();
    idle(); mtc_we = 1; mtc_mask = 8'h02; mtc_data = 32'hFFFF_FFFF; cmp_we = 1; cmp_fld = 1;
    cmp_val = 4'h6; cycle();
    idle(); cycle();

    req = "R7";
    idle(); irq_restore = 1; irq_snap = 32'hDEAD_BEEF; cmp_we = 1; cmp_fld = 3;
    cmp_val = 4'h0; lcr_we = 1; lcr_dst = 5'd0; cycle();
    idle(); cycle();

    req = "R8";
    for (int f = 0; f < 8; f += 3) begin idle(); rsv_we = 1; rsv_fld = 3'(f); cycle(); end
    idle(); rel_we = 1; rel_fld = 3'd3; cycle();
    idle(); rel_we = 1; rel_fld = 3'd5; cycle();
    idle(); cycle();

    req = "R9";
    idle(); rsv_we = 1; rel_we = 1; rsv_fld = 3'd2; rel_fld = 3'd2; cycle();
    idle(); rsv_we = 1; rel_we = 1; rsv_fld = 3'd0; rel_fld = 3'd0; cycle();
    idle(); cycle();

    req = "R11";
    for (int i = 0; i < 8; i++) begin
      idle(); chk_s0_v = 1; chk_s0 = 3'(i); cycle();
      idle(); chk_s1_v = 1; chk_s1 = 3'(i); cycle();
      idle(); chk_t_v = 1; chk_t = 3'(i); cycle();
    end
    idle(); chk_s0 = 3'd2; chk_s1 = 3'd6; chk_t = 3'd0; cycle();

    req = "R10";
    idle(); irq_restore = 1; irq_snap = 32'h0F0F_00FF; rsv_we = 1; rsv_fld = 3'd4; cycle();
    idle(); chk_t_v = 1; chk_t = 3'd4; cycle();

    req = "R6";
    for (int n = 0; n < 3000; n++) begin
      idle();
      cmp_we = 1'($urandom_range(0, 1)); cmp_fld = 3'($urandom); cmp_val = 4'($urandom);
      rec_we = 1'($urandom_range(0, 1)); rec_unit = 1'($urandom); rec_val = 4'($urandom);
      mtc_we = 1'($urandom_range(0, 1)); mtc_mask = 8'($urandom); mtc_data = $urandom;
      lcr_we = 1'($urandom_range(0, 1)); lcr_op = 2'($urandom);
      lcr_a = 5'($urandom); lcr_b = 5'($urandom); lcr_dst = 5'($urandom);
      irq_restore = ($urandom_range(0, 31) == 0); irq_snap = $urandom;
      rsv_we = 1'($urandom); rsv_fld = 3'($urandom);
      rel_we = 1'($urandom); rel_fld = 3'($urandom);
      chk_s0_v = 1'($urandom); chk_s0 = 3'($urandom);
      chk_s1_v = 1'($urandom); chk_s1 = 3'($urandom);
      chk_t_v = 1'($urandom); chk_t = 3'($urandom);
      cycle();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog %s act=hung exp=finished", req);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule